// File: doc/BRIEF.md
# Peripheral Access Permission Controller

This block holds access rights for six on-chip peripherals in three byte-wide control registers and judges every peripheral bus access against them. Each register carries two 4-bit slices. A slice is a 3-bit permission code plus a lock bit. The code grants different read and write rights in supervisor mode and in user mode. Once a lock bit is set, the register cannot be written again until system reset.

Software reaches the registers through a simple byte-wide port. Every port access returns an error flag in the same cycle. A separate combinational checker takes a peripheral index, a read/write flag and a supervisor/user flag. It answers with either allow or error-terminate.

Top module: `periph_perm_ctl`

## Requirements
- R1: After reset, all three registers read 0x00. That value is code 000 with both locks clear.
- R2: The registers sit at byte offsets 0x24, 0x25 and 0x26, with register n at 0x24+n. In each register, bit 7 is the upper lock, bits 6:4 are the upper code, bit 3 is the lower lock and bits 2:0 are the lower code. A read of an in-range offset returns the stored byte and never raises an error.
- R3: A write to an unlocked register replaces all eight bits, both codes and both locks, at the next clock edge. The write reports no error.
- R4: A write to a register whose upper or lower lock is set raises the error flag in the same cycle and leaves the register unchanged.
- R5: A set lock bit stays set until reset. No write clears it.
- R6: Checker index 2n selects the upper slice of register n, and index 2n+1 selects the lower slice.
- R7: The supervisor grants per code are: 000, 100, 101 and 110 give read and write; 001, 010 and 011 give read only; 111 gives nothing. The user grants per code are: 100 and 110 give read and write; 010 and 101 give read only; 000, 001, 011 and 111 give nothing.
- R8: The checker is combinational. chk_allow is high exactly when the requested access is granted, and chk_err is its complement. Checker indices 6 and 7 always give an error.
- R9: A port access to an offset outside 0x24 to 0x26 raises the error flag, reads 0x00 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| reg_err | output | 1 | Access error, combinational |
| chk_idx | input | 3 | Peripheral index under check |
| chk_write | input | 1 | 1 = write access, 0 = read access |
| chk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| chk_allow | output | 1 | Access granted |
| chk_err | output | 1 | Access must be error-terminated |

## Verification
The flags reg_err, reg_rdata, chk_allow and chk_err follow their inputs in the same cycle. The bench therefore samples them 1 ns after it drives inputs on the falling edge, before the next rising edge. A register write takes effect at the first rising edge after it is presented. Each readback and checker probe is made in a later cycle, after that edge.

// File: rtl/periph_perm_ctl.sv
module periph_perm_ctl #(
  parameter int         NREG = 3,
  parameter logic [7:0] BASE = 8'h24,
  localparam int        NPER = 2 * NREG,
  localparam int        IW   = $clog2(NPER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          reg_err,
  input  logic [IW-1:0] chk_idx,
  input  logic          chk_write,
  input  logic          chk_super,
  output logic          chk_allow,
  output logic          chk_err
);

  logic [7:0] ctl [NREG];
  logic [7:0] off;
  logic       hit, sel_locked;
  logic [2:0] code;
  logic       idx_ok;

  assign off = reg_addr - BASE;
  assign hit = off < 8'(NREG);

  always_comb begin
    reg_rdata  = 8'h00;
    sel_locked = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (hit && off == 8'(i)) begin
        reg_rdata  = ctl[i];
        sel_locked = ctl[i][7] | ctl[i][3];
      end
  end

  assign reg_err = reg_en & (~hit | (reg_we & sel_locked));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr;
    assign wr = reg_en & reg_we & hit & (off == 8'(g)) & ~(ctl[g][7] | ctl[g][3]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  ctl[g] <= 8'h00;
      else if (wr) ctl[g] <= reg_wdata;

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[g][7] | ctl[g][3]) |=> ctl[g] == $past(ctl[g]));
    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[g][7] && ctl[g][3]) |=> (ctl[g][7] && ctl[g][3]));
    // R9
    oob_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && !hit) |=> ctl[g] == $past(ctl[g]));
  end

  always_comb begin
    code = 3'b111;
    for (int i = 0; i < NPER; i++)
      if (chk_idx == IW'(i))
        code = (i % 2 == 0) ? ctl[i/2][6:4] : ctl[i/2][2:0];
  end

  assign idx_ok = chk_idx < IW'(NPER);

  function automatic logic granted(input logic [2:0] c, input logic sup, input logic wr);
    logic rd_s, wr_s, rd_u, wr_u;
    rd_s = (c != 3'b111);
    wr_s = (c == 3'b000) | c[2] & (c != 3'b111);
    rd_u = (c == 3'b010) | c[2] & (c != 3'b111);
    wr_u = c[2] & ~c[0] ;
    return sup ? (wr ? wr_s : rd_s) : (wr ? wr_u : rd_u);
  endfunction

  assign chk_allow = idx_ok & granted(code, chk_super, chk_write);
  assign chk_err   = ~chk_allow;

  // R2
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && hit) |-> !reg_err);
  // R8
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_idx >= IW'(NPER)) |-> (chk_err && !chk_allow));
  // R7
  code7_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b111) |-> !chk_allow);

endmodule

// File: tb/periph_perm_ctl_bench.sv
module periph_perm_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_err;
  logic [2:0] chk_idx = 0;
  logic chk_write = 0, chk_super = 0, chk_allow, chk_err;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  periph_perm_ctl u_periph_perm_ctl (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_grant(input logic [2:0] c, input logic sup, input logic wr);
    case ({sup, wr})
      2'b10: return c != 3'd7;
      2'b11: return c == 3'd0 || c == 3'd4 || c == 3'd5 || c == 3'd6;
      2'b00: return c == 3'd2 || c == 3'd4 || c == 3'd5 || c == 3'd6;
      default: return c == 3'd4 || c == 3'd6;
    endcase
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, output logic err);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    #1 err = reg_err;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output logic err);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata; err = reg_err;
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic probe(input logic [2:0] idx, input logic sup, input logic wr, output logic al, output logic er);
    @(negedge clk);
    chk_idx = idx; chk_super = sup; chk_write = wr;
    #1 al = chk_allow; er = chk_err;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic e, al, er;
    for (int n = 0; n < 3; n++) begin
      reg_read(8'h24 + 8'(n), d, e);
      check("R1 reset value", d, 8'h00);
      check("R2 read err", {7'd0, e}, 8'd0);
    end
    probe(3'd0, 1, 1, al, er);
    check("R1 reset code 000 sup write", {7'd0, al}, 8'd1);
  endtask

  task automatic t_readback;
    logic [7:0] d; logic e;
    logic [7:0] pat [3] = '{8'h25, 8'h61, 8'h77};
    for (int n = 0; n < 3; n++) begin
      reg_write(8'h24 + 8'(n), pat[n], e);
      check("R3 write err", {7'd0, e}, 8'd0);
    end
    for (int n = 0; n < 3; n++) begin
      reg_read(8'h24 + 8'(n), d, e);
      check("R3 readback", d, pat[n]);
    end
  endtask

  task automatic t_perm;
    logic e, al, er;
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 3; n++)
        reg_write(8'h24 + 8'(n), {1'b0, 3'(c), 1'b0, 3'(7 - c)}, e);
      for (int p = 0; p < 6; p++)
        for (int m = 0; m < 4; m++) begin
          logic [2:0] cc;
          cc = (p % 2 == 0) ? 3'(c) : 3'(7 - c);
          probe(3'(p), m[1], m[0], al, er);
          check("R6 R7 R8 allow", {7'd0, al}, {7'd0, exp_grant(cc, m[1], m[0])});
          check("R8 err complement", {7'd0, er}, {7'd0, ~exp_grant(cc, m[1], m[0])});
        end
    end
    for (int p = 6; p < 8; p++) begin
      probe(3'(p), 1, 0, al, er);
      check("R8 bad index err", {6'd0, al, er}, 8'b01);
    end
  endtask

  task automatic t_oob;
    logic [7:0] d; logic e;
    reg_write(8'h24, 8'h42, e);
    reg_write(8'h23, 8'h11, e);
    check("R9 oob write err", {7'd0, e}, 8'd1);
    reg_write(8'h27, 8'h11, e);
    check("R9 oob write err hi", {7'd0, e}, 8'd1);
    reg_read(8'h27, d, e);
    check("R9 oob read data", d, 8'h00);
    check("R9 oob read err", {7'd0, e}, 8'd1);
    reg_read(8'h24, d, e);
    check("R9 no effect", d, 8'h42);
  endtask

  task automatic t_lock;
    logic [7:0] d; logic e, al, er;
    reg_write(8'h24, 8'h0C, e);
    check("R3 lock write ok", {7'd0, e}, 8'd0);
    reg_write(8'h24, 8'h00, e);
    check("R4 lower-lock write err", {7'd0, e}, 8'd1);
    reg_read(8'h24, d, e);
    check("R5 lock kept", d, 8'h0C);
    check("R2 locked read err", {7'd0, e}, 8'd0);
    reg_write(8'h25, 8'hD2, e);
    reg_write(8'h25, 8'h46, e);
    check("R4 upper-lock write err", {7'd0, e}, 8'd1);
    reg_read(8'h25, d, e);
    check("R4 unchanged", d, 8'hD2);
    probe(3'd2, 0, 0, al, er);
    check("R6 idx2 upper code 101 user read", {7'd0, al}, 8'd1);
    probe(3'd3, 0, 0, al, er);
    check("R6 idx3 lower code 010 user read", {7'd0, al}, 8'd1);
    probe(3'd2, 0, 1, al, er);
    check("R7 code 101 user write denied", {7'd0, er}, 8'd1);
    reg_write(8'h26, 8'h31, e);
    reg_read(8'h26, d, e);
    check("R3 third reg unaffected by locks", d, 8'h31);
  endtask

  initial begin
    #50000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readback();
    t_perm();
    t_oob();
    t_lock();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule